// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

The block counts prescaled peripheral-clock cycles with a small up-counter and reports each counter overflow in one of two ways, chosen by a mode bit. In watchdog mode an overflow sets a sticky watchdog flag and emits a one-cycle reset request. Software must reload the counter before it wraps to avoid that request. In interval mode an overflow sets a sticky interval flag and emits a one-cycle interrupt request. The counter wraps to zero and keeps running, so it produces a periodic tick.

A free-running prescaler counts cycles on which `clk_en` is high. A 3-bit select field picks one of eight power-of-two taps: 1, 4, 16, 32, 64, 256, 1024 or 4096. Because the prescaler is not restarted when the timer starts, the first overflow after a start can come early by up to one prescaled period. Every later overflow is exact. Software reaches a control/status register and the counter through a two-address write port and a combinational read port.

Top module: `dmw_top`

## Requirements
- R1: The select field (control bits [2:0]) sets the divide ratio: 0→1, 1→4, 2→16, 3→32, 4→64, 5→256, 6→1024, 7→4096. With `clk_en` held high, consecutive overflows are 2^CNT_W × ratio clock cycles apart.
- R2: In interval mode (control bit 6 = 0), an overflow sets the interval flag (control bit 4). The interrupt request is high for exactly the one cycle after the edge on which the counter leaves its all-ones value. The counter becomes 0 on that edge and keeps counting.
- R3: In watchdog mode (control bit 6 = 1), an overflow sets the watchdog flag (control bit 5) and raises `rst_req` for exactly one cycle, with the same timing as R2.
- R4: The watchdog flag and `rst_req` never change in interval mode. The interval flag and `irq` never change in watchdog mode.
- R5: A write to the control register leaves the select field unchanged if the timer was running (control bit 7 = 1) before that write. If the timer was stopped, the field is taken from the written value.
- R6: After reset, the control register reads 0x00, the counter reads 0, and `irq` and `rst_req` are low.
- R7: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit has no effect. An overflow in the same cycle as a clear wins, so the flag is set.
- R8: While the run bit is 0, the counter holds its value. A write to address 1 loads the counter and takes priority over counting, so periodic reloads keep a watchdog from overflowing.
- R9: The prescaler and the counter advance only on cycles where `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Count enable for the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control/status, 1 = counter |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | One-cycle interval overflow request |
| rst_req | output | 1 | One-cycle watchdog overflow request |

## Verification
The bench uses a 3-bit counter. It sweeps all eight select codes in interval mode and measures the spacing between consecutive interrupts. Each spacing is distinct, so a wrong tap or a swapped code shows up as a wrong period. A counter preloaded to 5 at ratio 1 pins down the exact overflow cycle in each mode, which separates a late or long pulse from a correct one. A further sequence covers writes to the select field while running, flag writes with ones and zeros, a stopped counter, a gated `clk_en`, and periodic reloads against a later unserviced timeout. Each of these shows whether the input was ignored or acted on.

// File: rtl/dmw_pkg.sv
// Shared constants and types for the dual-mode watchdog/interval timer.
// Assumes an 8-bit register interface; the counter width is a top parameter.
package dmw_pkg;
    localparam int REG_W   = 8;
    localparam int SEL_W   = 3;
    localparam int NUM_DIV = 1 << SEL_W;

    // control/status register bit positions
    localparam int B_RUN  = 7;
    localparam int B_MODE = 6;
    localparam int B_WFLG = 5;
    localparam int B_IFLG = 4;

    typedef enum logic {MODE_INTERVAL = 1'b0, MODE_WATCHDOG = 1'b1} mode_t;

    // log2 of the division ratio for each select code
    function automatic int div_shift(input logic [SEL_W-1:0] s);
        case (s)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 12;
        endcase
    endfunction

    localparam int PRE_W = div_shift(3'd7);
endpackage

// File: rtl/dmw_prescaler.sv
// Free-running prescaler. Counts enabled cycles and issues a one-cycle
// tick when the low bits of the selected tap are all ones.
// Assumes sel changes only while the timer is stopped.
module dmw_prescaler
    import dmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0]   pre;
    logic [NUM_DIV-1:0] tap_hit;

    // advance the prescale count on every enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre <= '0;
        else if (clk_en)
            pre <= pre + PRE_W'(1);
    end

    // one tap detector per select code
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
        localparam int SH = div_shift(SEL_W'(g));
        if (SH == 0) begin : g_div1
            assign tap_hit[g] = 1'b1;
        end else begin : g_divn
            assign tap_hit[g] = &pre[SH-1:0];
        end
    end

    assign tick = clk_en & tap_hit[sel];

    AST_TICK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) !clk_en |=> $stable(pre)); // R9
endmodule

// File: rtl/dmw_counter.sv
// Up-counter of CNT_W bits with a software load. Overflow is reported
// combinationally when a counting tick meets the all-ones value.
// Assumes load and run come from the register block.
module dmw_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign ovf = run & tick & ~load & (cnt == CNT_MAX);

    // load has priority, else count on tick while running
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && tick)
            cnt <= cnt + CNT_W'(1);
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(!run && !load) |-> $stable(cnt)); // R8
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> (cnt == '0)); // R2
    AST_NO_EN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !load) |=> $stable(cnt)); // R9
endmodule

// File: rtl/dmw_ctrl.sv
// Control/status register: run, mode, clock select and two sticky
// overflow flags. Turns an overflow into a registered one-cycle request
// on the output that belongs to the current mode.
module dmw_ctrl
    import dmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             ovf,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic [REG_W-1:0] ctrl_q,
    output logic             irq,
    output logic             rst_req
);
    mode_t mode;
    logic  wflag, iflag;
    logic  clr_w, clr_i, set_w, set_i;

    assign clr_w = wr_ctrl & ~wdata[B_WFLG];
    assign clr_i = wr_ctrl & ~wdata[B_IFLG];
    assign set_w = ovf & (mode == MODE_WATCHDOG);
    assign set_i = ovf & (mode == MODE_INTERVAL);

    // run and mode follow every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            mode <= MODE_INTERVAL;
        end else if (wr_ctrl) begin
            run  <= wdata[B_RUN];
            mode <= mode_t'(wdata[B_MODE]);
        end
    end

    // clock select accepted only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (wr_ctrl && !run)
            sel <= wdata[SEL_W-1:0];
    end

    // sticky flags: overflow sets, written zero clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wflag <= 1'b0;
            iflag <= 1'b0;
        end else begin
            if (set_w)      wflag <= 1'b1;
            else if (clr_w) wflag <= 1'b0;
            if (set_i)      iflag <= 1'b1;
            else if (clr_i) iflag <= 1'b0;
        end
    end

    // one-cycle request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= set_i;
            rst_req <= set_w;
        end
    end

    assign ctrl_q = {run, mode, wflag, iflag, 1'b0, sel};

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(run) |-> $stable(sel)); // R5
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R2
    AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R3
    AST_IFLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(iflag) |-> irq); // R4
    AST_WFLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wflag) |-> rst_req); // R4
    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(irq && rst_req)); // R4
    AST_WFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(wflag && !clr_w) |-> wflag); // R7
    AST_IFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(iflag && !clr_i) |-> iflag); // R7
endmodule

// File: rtl/dmw_top.sv
// Dual-mode watchdog / interval timer top. Address 0 is control/status,
// address 1 is the counter. Reads are combinational; writes take effect
// on the next clock edge. Assumes CNT_W does not exceed the register width.
module dmw_top
    import dmw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq,
    output logic             rst_req
);
    logic             run, tick, ovf, wr_ctrl, wr_cnt;
    logic [SEL_W-1:0] sel;
    logic [REG_W-1:0] ctrl_q;
    logic [CNT_W-1:0] cnt;

    assign wr_ctrl = wr_en & ~addr;
    assign wr_cnt  = wr_en &  addr;

    dmw_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .sel    (sel),
        .tick   (tick)
    );

    dmw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .load     (wr_cnt),
        .load_val (wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .ovf      (ovf)
    );

    dmw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .ovf     (ovf),
        .run     (run),
        .sel     (sel),
        .ctrl_q  (ctrl_q),
        .irq     (irq),
        .rst_req (rst_req)
    );

    // read mux
    assign rdata = addr ? REG_W'(cnt) : ctrl_q;

    AST_OVF_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) (irq || rst_req) |-> $past(run)); // R8
endmodule

// File: tb/dmw_top_test.sv
module dmw_top_test;
    localparam int CW = 3;
    localparam logic [7:0] RUN = 8'h80, WDG = 8'h40, WF = 8'h20, IF = 8'h10;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, wr_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic irq, rst_req;
    int checks = 0, fails = 0;
    int irq_seen = 0, rst_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dmw_top #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always @(negedge clk) begin
        if (rst_n && irq)     irq_seen++;
        if (rst_n && rst_req) rst_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic int ratio(input int s);
        case (s)
            0: return 1;    1: return 4;    2: return 16;   3: return 32;
            4: return 64;   5: return 256;  6: return 1024; default: return 4096;
        endcase
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, c0;
        int n, base_i, base_r;
        repeat (5) @(negedge clk);
        // R6 reset values
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, v); chk(v == 8'h00, "R6 ctrl", v, 0);
        rd(1'b1, v); chk(v == 8'h00, "R6 count", v, 0);
        chk(!irq && !rst_req, "R6 outputs", {irq, rst_req}, 0);

        // R7 writing ones to flags while clear has no effect
        wr(1'b0, WF | IF);
        rd(1'b0, v); chk(v == 8'h00, "R7 set-by-write", v, 0);

        // R2 exact interval overflow timing at ratio 1
        wr(1'b1, 8'd5);
        base_r = rst_seen;
        wr(1'b0, RUN);
        rd(1'b1, v); chk(v == 8'd5, "R2 start", v, 5);
        @(negedge clk); @(negedge clk);
        rd(1'b1, v); chk(v == 8'd7 && !irq, "R2 pre-overflow", {irq, v}, 7);
        @(negedge clk);
        rd(1'b1, v); chk(v == 8'd0 && irq, "R2 wrap and irq", {irq, v}, 9'h100);
        rd(1'b0, v); chk(v == (RUN | IF), "R2 iflag", v, RUN | IF);
        @(negedge clk);
        rd(1'b1, v); chk(v == 8'd1 && !irq, "R2 one-cycle, keeps counting", {irq, v}, 1);
        chk(rst_seen == base_r, "R4 no rst_req in interval", rst_seen - base_r, 0);

        // R7 writing 1 keeps flag, writing 0 clears
        wr(1'b0, IF);
        rd(1'b0, v); chk(v[4] == 1'b1, "R7 write-one keeps", v[4], 1);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk(v == 8'h00, "R7 write-zero clears", v, 0);

        // R3 exact watchdog overflow timing
        wr(1'b1, 8'd5);
        base_i = irq_seen;
        wr(1'b0, RUN | WDG);
        @(negedge clk); @(negedge clk);
        chk(!rst_req, "R3 early", rst_req, 0);
        @(negedge clk);
        chk(rst_req, "R3 rst_req pulse", rst_req, 1);
        rd(1'b0, v); chk(v == (RUN | WDG | WF), "R3/R4 wflag only", v, RUN | WDG | WF);
        @(negedge clk);
        chk(!rst_req, "R3 one-cycle", rst_req, 0);
        chk(irq_seen == base_i, "R4 no irq in watchdog", irq_seen - base_i, 0);

        // R8 service by reloading: no timeout
        wr(1'b0, RUN | WDG);   // clears wflag
        base_r = rst_seen;
        for (int k = 0; k < 30; k++) begin
            wr(1'b1, 8'd0);
            repeat (3) @(negedge clk);
        end
        chk(rst_seen == base_r, "R8 serviced watchdog", rst_seen - base_r, 0);
        rd(1'b0, v); chk(v[5] == 1'b0, "R8 no wflag when serviced", v[5], 0);
        repeat (12) @(negedge clk);
        chk(rst_seen == base_r + 1, "R3 unserviced timeout", rst_seen - base_r, 1);

        // R8 stopped counter holds
        wr(1'b0, 8'h00);
        wr(1'b1, 8'd3);
        repeat (20) @(negedge clk);
        rd(1'b1, v); chk(v == 8'd3, "R8 hold while stopped", v, 3);

        // R9 clk_en low freezes counting
        wr(1'b0, RUN);
        @(negedge clk);
        clk_en = 1'b0;
        rd(1'b1, c0);
        base_i = irq_seen;
        repeat (20) @(negedge clk);
        rd(1'b1, v); chk(v == c0 && irq_seen == base_i, "R9 clk_en gate", v, c0);
        clk_en = 1'b1;
        @(negedge clk);
        rd(1'b1, v); chk(v == ((c0 + 1) & 8'h7), "R9 resume", v, (c0 + 1) & 7);

        // R5 select ignored while running
        wr(1'b0, 8'h00);
        wr(1'b0, RUN | 8'd2);
        wr(1'b0, RUN | 8'd5);
        rd(1'b0, v); chk(v[2:0] == 3'd2, "R5 running write", v[2:0], 2);
        wr(1'b0, 8'd5);
        rd(1'b0, v); chk(v[2:0] == 3'd2, "R5 stopping write", v[2:0], 2);
        wr(1'b0, 8'd5);
        rd(1'b0, v); chk(v[2:0] == 3'd5, "R5 stopped write", v[2:0], 5);

        // R1 sweep of every ratio in interval mode
        base_r = rst_seen;
        for (int s = 0; s < 8; s++) begin
            wr(1'b0, 8'(s));
            wr(1'b1, 8'd0);
            wr(1'b0, RUN | 8'(s));
            n = 0;
            while (!irq && n < 50000) begin @(negedge clk); n++; end
            n = 0;
            do begin @(negedge clk); n++; end while (!irq && n < 50000);
            chk(n == (8 * ratio(s)), $sformatf("R1 period sel=%0d", s), n, 8 * ratio(s));
            rd(1'b0, v); chk(v[5:4] == 2'b01, "R4 flags in interval sweep", v[5:4], 1);
            wr(1'b0, 8'h00);
        end
        chk(rst_seen == base_r, "R4 no rst_req in sweep", rst_seen - base_r, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule